// File: doc/BRIEF.md
# Prescaled Down-Counting Timer

This block is an 8-bit down-counter fed by a free-running 7-bit prescaler. Each prescaler advance happens on a cycle where the single clock-enable input `tickEn` is high. A 3-bit select code picks which prescaler stage produces a counter step, so the counter steps once every 1, 2, 4 and so on up to 128 ticks. When the counter steps from one to zero, an interrupt flag is set. The counter then keeps stepping and wraps through 0xFF.

Software reaches the block through a two-register bus. Address 0 holds the control register: flag, mask, prescaler clear and divide select. Address 1 holds the counter value. Writes take effect on the clock edge. Reads return the selected register combinationally. The interrupt request output is high while the flag is set and the mask bit is clear. Any global masking in the processor is applied outside this block.

Top module: `tick_down_timer`

## Requirements
- R1: After reset, the control register reads 0x44 (flag clear, masked, divide code 4), the counter reads 0xFF, `irqReq` is low and the prescaler is zero.
- R2: The control register at address 0 has this layout. Bit 7 is the flag. Bit 6 is the mask, where 1 means masked. Bit 3 is the prescaler clear. Bits 2:0 are the divide code. Bits 5:4 and bit 3 always read 0. The counter is at address 1.
- R3: With divide code n, the counter steps down once every 2^n cycles with `tickEn` high, counted from a zero prescaler. Code 0 steps on every tick and code 7 steps every 128 ticks.
- R4: A write to address 1 loads the counter. If a step would happen in the same cycle, the written value is kept.
- R5: Each step subtracts one modulo 256, so a step from 0x00 gives 0xFF and counting continues.
- R6: The flag is set by the step that takes the counter from 0x01 to 0x00.
- R7: Writing 0 to bit 7 clears the flag. Writing 1 leaves the flag as it is. A flag-setting step in the same cycle as a clearing write leaves the flag set.
- R8: `irqReq` is high exactly when the flag is set and the mask bit is 0.
- R9: Writing 1 to bit 3 zeroes the prescaler and suppresses any counter step in that cycle.
- R10: While `tickEn` is low, the prescaler and the counter hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickEn | input | 1 | Count-source enable; one prescaler advance per high cycle |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 1 | Register select: 0 control, 1 counter |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for the selected register |
| irqReq | output | 1 | Interrupt request |

## Verification
Two pairs of events can land in the same cycle: a software write against a counter step, and a flag-clearing write against the step that sets the flag. The bench provokes each pair by raising `tickEn` in the same cycle as the write, with a divide code of 0 so that a step is certain. The first pair is judged by the counter holding the written value. The second is judged by the flag reading as set. The bench also issues a prescaler-clear write in the middle of a divide period and checks that the next step comes a full period after the clear.

// File: rtl/dtm_pkg.sv
package dtm_pkg;
  localparam int CNT_W   = 8;
  localparam int PRE_W   = 7;
  localparam int SEL_W   = $clog2(PRE_W + 1);
  localparam int NTAP    = PRE_W + 1;
  localparam int DIV_RST = 4;
  // control register bit positions
  localparam int FLAG_BIT = 7;
  localparam int MASK_BIT = 6;
  localparam int PCLR_BIT = 3;

  typedef struct packed {
    logic             loadCnt;
    logic             preClr;
    logic [CNT_W-1:0] loadVal;
    logic [SEL_W-1:0] divSel;
  } dpStrobe_t;
endpackage

// File: rtl/dtm_datapath.sv
module dtm_datapath
  import dtm_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  dpStrobe_t        stb,
  output logic [CNT_W-1:0] cntQ,
  output logic             termHit
);
  logic [PRE_W-1:0] preQ;
  logic [NTAP-1:0]  tapHit;
  logic             stepEn;

  // tapHit[k]: the low k prescaler bits are all ones, so the next tick ends a 2^k period
  assign tapHit[0] = 1'b1;
  generate
    for (genvar k = 1; k < NTAP; k++) begin : g_tap
      assign tapHit[k] = &preQ[k-1:0];
    end
  endgenerate

  assign stepEn  = tickEn && !stb.preClr && tapHit[stb.divSel];
  assign termHit = stepEn && !stb.loadCnt && (cntQ == CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preQ <= '0;
    end else if (stb.preClr) begin
      preQ <= '0;
    end else if (tickEn) begin
      preQ <= preQ + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '1;
    end else if (stb.loadCnt) begin
      cntQ <= stb.loadVal;
    end else if (stepEn) begin
      cntQ <= cntQ - 1'b1;
    end
  end

  AST_PRE_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    stb.preClr |=> preQ == '0); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !stb.loadCnt && !stb.preClr) |=> ($stable(cntQ) && $stable(preQ))); // R10
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadCnt |=> cntQ == $past(stb.loadVal)); // R4
  AST_TERM_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    termHit |=> cntQ == '0); // R6
  AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && !stb.preClr && !stb.loadCnt && stb.divSel == '0)
      |=> cntQ == CNT_W'($past(cntQ) - 1'b1)); // R5
endmodule

// File: rtl/dtm_ctrl.sv
module dtm_ctrl
  import dtm_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWr,
  input  logic             busAddr,
  input  logic [CNT_W-1:0] busWrData,
  input  logic             termHit,
  output dpStrobe_t        stb,
  output logic [CNT_W-1:0] ctrlRd,
  output logic             irqReq
);
  logic             flagQ;
  logic             maskQ;
  logic [SEL_W-1:0] selQ;
  logic             ctrlWr;
  logic             cntWr;

  assign ctrlWr = busWr && !busAddr;
  assign cntWr  = busWr && busAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= 1'b1;
      selQ  <= SEL_W'(DIV_RST);
    end else if (ctrlWr) begin
      maskQ <= busWrData[MASK_BIT];
      selQ  <= busWrData[SEL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= 1'b0;
    end else if (termHit) begin
      flagQ <= 1'b1;
    end else if (ctrlWr && !busWrData[FLAG_BIT]) begin
      flagQ <= 1'b0;
    end
  end

  always_comb begin
    stb.loadCnt = cntWr;
    stb.preClr  = ctrlWr && busWrData[PCLR_BIT];
    stb.loadVal = busWrData;
    stb.divSel  = selQ;
  end

  always_comb begin
    ctrlRd                = '0;
    ctrlRd[FLAG_BIT]      = flagQ;
    ctrlRd[MASK_BIT]      = maskQ;
    ctrlRd[SEL_W-1:0]     = selQ;
  end

  assign irqReq = flagQ && !maskQ;

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rstN)
    termHit |=> flagQ); // R7
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!termHit && !ctrlWr) |=> $stable(flagQ)); // R6
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    maskQ |-> !irqReq); // R8
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlWr |=> $stable(selQ)); // R3
endmodule

// File: rtl/tick_down_timer.sv
module tick_down_timer
  import dtm_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             busWr,
  input  logic             busAddr,
  input  logic [CNT_W-1:0] busWrData,
  output logic [CNT_W-1:0] busRdData,
  output logic             irqReq
);
  dpStrobe_t        stb;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] ctrlRd;
  logic             termHit;

  dtm_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busWr     (busWr),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .termHit   (termHit),
    .stb       (stb),
    .ctrlRd    (ctrlRd),
    .irqReq    (irqReq)
  );

  dtm_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .tickEn  (tickEn),
    .stb     (stb),
    .cntQ    (cntQ),
    .termHit (termHit)
  );

  assign busRdData = busAddr ? cntQ : ctrlRd;
endmodule

// File: tb/sim_tick_down_timer.sv
module sim_tick_down_timer;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;
  localparam int NVEC       = 8;
  // {divCode, loadValue, ticks[15:0], expectedCount, expectedFlag}
  localparam logic [47:0] VEC [NVEC] = '{
    48'h00_0A_0005_05_00,
    48'h00_03_0003_00_01,
    48'h00_02_0004_FE_01,
    48'h02_20_000A_1E_00,
    48'h04_01_0010_00_01,
    48'h07_05_012C_03_00,
    48'h01_00_0006_FD_00,
    48'h03_01_000F_00_01
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       busWr = 1'b0;
  logic       busAddr = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic       irqReq;
  int         checks = 0;
  int         errors = 0;
  logic [7:0] rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  tick_down_timer u0 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busWr(busWr),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .irqReq(irqReq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic a, input logic [7:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rdReg(input logic a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic doTicks(input int n);
    @(negedge clk);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic finishRun;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    rdReg(1'b0, rd); check("R1 ctrl", rd, 8'h44);
    rdReg(1'b1, rd); check("R1 count", rd, 8'hFF);
    check("R1 irq", {7'd0, irqReq}, 8'h00);

    // table walk: R3, R5, R6
    for (int i = 0; i < NVEC; i++) begin
      logic [47:0] v;
      v = VEC[i];
      wrReg(1'b0, 8'h48 | v[47:40]);   // masked, flag clear, prescaler clear, code
      wrReg(1'b1, v[39:32]);
      doTicks(int'(v[31:16]));
      rdReg(1'b1, rd); check($sformatf("R3/R5 vec%0d count", i), rd, v[15:8]);
      rdReg(1'b0, rd); check($sformatf("R6 vec%0d flag", i), {7'd0, rd[7]}, v[7:0]);
      check($sformatf("R8 vec%0d masked irq", i), {7'd0, irqReq}, 8'h00);
    end

    // R2 / R9: layout and read-as-zero bits; writing 1 to the flag does not set it
    wrReg(1'b0, 8'h08);
    wrReg(1'b0, 8'hFF);
    rdReg(1'b0, rd); check("R2 ctrl layout", rd, 8'h47);

    // R8 / R7 unmasked request, write-1 keeps flag, write-0 clears
    wrReg(1'b0, 8'h08);
    wrReg(1'b1, 8'h01);
    doTicks(1);
    rdReg(1'b0, rd); check("R6 flag at zero", rd, 8'h80);
    check("R8 irq unmasked", {7'd0, irqReq}, 8'h01);
    wrReg(1'b0, 8'hC0);
    rdReg(1'b0, rd); check("R7 write 1 keeps flag", rd, 8'hC0);
    check("R8 irq masked", {7'd0, irqReq}, 8'h00);
    wrReg(1'b0, 8'h00);
    rdReg(1'b0, rd); check("R7 write 0 clears", rd, 8'h00);
    check("R8 irq after clear", {7'd0, irqReq}, 8'h00);

    // R7 set wins over clearing write in same cycle
    wrReg(1'b1, 8'h01);
    @(negedge clk);
    tickEn = 1'b1; busWr = 1'b1; busAddr = 1'b0; busWrData = 8'h00;
    @(negedge clk);
    tickEn = 1'b0; busWr = 1'b0;
    rdReg(1'b0, rd); check("R7 set wins", {7'd0, rd[7]}, 8'h01);
    rdReg(1'b1, rd); check("R5 count at zero", rd, 8'h00);

    // R4 load wins over step
    @(negedge clk);
    tickEn = 1'b1; busWr = 1'b1; busAddr = 1'b1; busWrData = 8'h55;
    @(negedge clk);
    tickEn = 1'b0; busWr = 1'b0;
    rdReg(1'b1, rd); check("R4 load wins", rd, 8'h55);

    // R9 prescaler clear suppresses same-cycle step
    wrReg(1'b1, 8'h10);
    @(negedge clk);
    tickEn = 1'b1; busWr = 1'b1; busAddr = 1'b0; busWrData = 8'h48;
    @(negedge clk);
    tickEn = 1'b0; busWr = 1'b0;
    rdReg(1'b1, rd); check("R9 step suppressed", rd, 8'h10);

    // R9 mid-period clear with code 2
    wrReg(1'b0, 8'h4A);
    doTicks(3);
    wrReg(1'b0, 8'h4A);
    doTicks(3);
    rdReg(1'b1, rd); check("R9 period restarted", rd, 8'h10);
    doTicks(1);
    rdReg(1'b1, rd); check("R3 step after full period", rd, 8'h0F);

    // R10 idle hold
    repeat (20) @(negedge clk);
    rdReg(1'b1, rd); check("R10 idle hold", rd, 8'h0F);

    finishRun();
  end
endmodule